// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block is the host side of an enhanced-mode parallel port. A host bus issues register accesses at eight byte offsets. Offsets 0 to 2 reach the data latch, the status view and the control register. Offset 3 starts a peripheral address cycle and offset 4 starts a peripheral data cycle. Each peripheral cycle drives a strobe low, waits for the peripheral to raise its wait line, then releases the strobe. A cycle that gets no answer within a programmable number of clocks fails and sets a sticky timeout flag.

A cycle runs only when the control register holds an exact pattern. For a write, the direction bit and all four signal bits must be clear except the initialise bit. For a read, the direction bit must also be set. Any other pattern makes the access complete at once with no bus activity. Data-port accesses may be 1, 2 or 4 bytes wide and are split into byte cycles, lowest byte first. While the byte cycles run, the host sees a busy indication, and a one-clock acknowledge with the read data marks completion.

Top module: `epp_host`

## Requirements
- R1: After reset, control reads 0xCC, the data latch reads 0xFF, status bit 0 is 0, `busy_o` is 0 and all peripheral strobes are high.
- R2: A write to offset 2 stores the value with bits 7:6 forced to 1, and a read of offset 2 returns it. `ctl_load_o` pulses with the acknowledge only if the stored value changes. `ctl_o` always shows stored bits 3:0.
- R3: A write to offset 0 stores the byte and drives it on `pd_o` while the port is idle. `data_load_o` pulses with the acknowledge only if the value differs from the one already latched.
- R4: When idle, `pd_oe_o` is the inverse of control bit 5. A read of offset 0 returns `pd_i` when bit 5 is 1 and the latched byte when bit 5 is 0.
- R5: A write to offset 3 or 4 starts bus cycles only when control bits {5,3,2,1,0} are 00100. Otherwise no strobe moves and the access is acknowledged on the next clock.
- R6: A read of offset 3 or 4 starts bus cycles only when control bits {5,3,2,1,0} are 10100. Otherwise it returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF. The data bus is never driven during a read cycle.
- R7: An address cycle (offset 3) pulses only `n_astrb_o` low. A data cycle (offset 4) pulses only `n_dstrb_o` low. `n_write_o` is low during write cycles and high otherwise.
- R8: A strobe stays low until `n_wait_i` is seen high and is released on the next clock. Write cycles present the byte on `pd_o`. Read cycles capture `pd_i` when `n_wait_i` is seen.
- R9: If `n_wait_i` stays low for TIMEOUT_CYC clocks of an asserted strobe, the strobe is released, the access ends, and the sticky timeout flag is set. A read of offset 1 returns that flag in bit 0 and `pstat_i` in bits 7:1.
- R10: A write to offset 1 with bit 0 = 1 clears the timeout flag. A write with bit 0 = 0 leaves it unchanged.
- R11: `size_i` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3) for offset 4. Bytes are transferred least significant first. Offset 3 is always one byte.
- R12: A multi-byte access stops at the first byte that times out. A read returns the bytes received so far, with the rest set to 0xFF.
- R13: `busy_o` is high from the clock after a peripheral access is accepted until its last byte cycle ends. `ack_o` is a one-clock pulse with valid `rdata_o`. A request is accepted only while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Data-port width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wdata_i | input | 32 | Write data, little-endian |
| rdata_o | output | 32 | Read data, valid with ack_o |
| busy_o | output | 1 | Peripheral byte cycles in progress |
| ack_o | output | 1 | Access complete pulse |
| pstat_i | input | 7 | Peripheral status lines, reported in status bits 7:1 |
| ctl_o | output | 4 | Control signal bits 3:0 toward the peripheral |
| ctl_load_o | output | 1 | Pulse: control value changed |
| data_load_o | output | 1 | Pulse: data latch changed |
| n_write_o | output | 1 | Low during write cycles |
| n_astrb_o | output | 1 | Address strobe, active low |
| n_dstrb_o | output | 1 | Data strobe, active low |
| n_wait_i | input | 1 | Peripheral ready, high ends the strobe |
| pd_o | output | 8 | Data bus out |
| pd_oe_o | output | 1 | Data bus output enable |
| pd_i | input | 8 | Data bus in |

## Verification
If the control register is corrupted, the fault shows on the next idle clock: `ctl_o` or `pd_oe_o` differs from a shadow copy the bench keeps, and the cycle gating also goes wrong. If the byte index or the response buffer goes wrong, the peripheral model sees the wrong byte order within one strobe, or the read word returns misplaced 0xFF lanes at its acknowledge. If the timeout counter is wrong, the strobe stays low for the wrong number of clocks, and a flag that is lost or stuck shows on the next status read.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;
  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_EADR = 3'd3;
  localparam logic [2:0] OFF_EDAT = 3'd4;

  localparam int unsigned CB_DIR = 5;

  // control bits that take part in the gating pattern: dir + 4 signal bits
  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STRB, SQ_REL} sq_state_e;

  function automatic logic [1:0] size_to_last(logic [1:0] sz);
    case (sz)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [31:0] last_mask(logic [1:0] last);
    case (last)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/epp_host_regs.sv
module epp_host_regs
  import epp_host_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       fail_i,
  input  logic [6:0] pstat_i,
  input  logic [7:0] pd_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic       to_o,
  output logic       ctl_load_o,
  output logic       data_load_o,
  output logic [7:0] rd_o
);
  logic [7:0] ctrl_q, data_q, ctrl_nx;
  logic       to_q, cl_q, dl_q;

  assign ctrl_nx = wdata_i | CTRL_FIXED;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      data_q <= 8'hFF;
      to_q   <= 1'b0;
      cl_q   <= 1'b0;
      dl_q   <= 1'b0;
    end else begin
      cl_q <= 1'b0;
      dl_q <= 1'b0;
      if (fail_i) to_q <= 1'b1;
      if (wr_i) begin
        case (addr_i)
          OFF_DATA: if (wdata_i != data_q) begin
            data_q <= wdata_i;
            dl_q   <= 1'b1;
          end
          OFF_STAT: if (wdata_i[0]) to_q <= 1'b0;
          OFF_CTRL: if (ctrl_nx != ctrl_q) begin
            ctrl_q <= ctrl_nx;
            cl_q   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      OFF_DATA: rd_o = ctrl_q[CB_DIR] ? pd_i : data_q;
      OFF_STAT: rd_o = {pstat_i, to_q};
      OFF_CTRL: rd_o = ctrl_q;
      default:  rd_o = 8'hFF;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign data_o      = data_q;
  assign to_o        = to_q;
  assign ctl_load_o  = cl_q;
  assign data_load_o = dl_q;
endmodule

// File: rtl/epp_host_seq.sv
module epp_host_seq
  import epp_host_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        wr_i,
  input  logic        adr_i,
  input  logic [1:0]  last_i,
  input  logic [31:0] wdata_i,
  input  logic        n_wait_i,
  input  logic [7:0]  pd_i,
  output logic        busy_o,
  output logic        wr_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [31:0] result_o,
  output logic [7:0]  byte_o,
  output logic        n_astrb_o,
  output logic        n_dstrb_o,
  output logic        n_write_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] CNT_END = CW'(TIMEOUT_CYC - 1);

  sq_state_e     st_q;
  logic [1:0]    idx_q, last_q;
  logic          wr_q, adr_q;
  logic [31:0]   buf_q;
  logic [CW-1:0] cnt_q;
  logic          to_hit, fin_ok;

  assign to_hit = (st_q == SQ_STRB) && !n_wait_i && (cnt_q == CNT_END);
  assign fin_ok = (st_q == SQ_REL) && (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      wr_q   <= 1'b0;
      adr_q  <= 1'b0;
      buf_q  <= '1;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (start_i) begin
          st_q   <= SQ_STRB;
          idx_q  <= '0;
          last_q <= last_i;
          wr_q   <= wr_i;
          adr_q  <= adr_i;
          buf_q  <= wr_i ? wdata_i : '1;
          cnt_q  <= '0;
        end
        SQ_STRB: begin
          if (n_wait_i) begin
            if (!wr_q) buf_q[{idx_q, 3'b000} +: 8] <= pd_i;
            st_q <= SQ_REL;
          end else if (to_hit) begin
            st_q <= SQ_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_REL: begin
          if (fin_ok) begin
            st_q <= SQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            cnt_q <= '0;
            st_q  <= SQ_STRB;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != SQ_IDLE);
  assign wr_o      = wr_q;
  assign done_o    = to_hit || fin_ok;
  assign fail_o    = to_hit;
  assign result_o  = buf_q & last_mask(last_q);
  assign byte_o    = buf_q[{idx_q, 3'b000} +: 8];
  assign n_astrb_o = !((st_q == SQ_STRB) && adr_q);
  assign n_dstrb_o = !((st_q == SQ_STRB) && !adr_q);
  assign n_write_o = !(busy_o && wr_q);
endmodule

// File: rtl/epp_host.sv
module epp_host
  import epp_host_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 500
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        busy_o,
  output logic        ack_o,
  input  logic [6:0]  pstat_i,
  output logic [3:0]  ctl_o,
  output logic        ctl_load_o,
  output logic        data_load_o,
  output logic        n_write_o,
  output logic        n_astrb_o,
  output logic        n_dstrb_o,
  input  logic        n_wait_i,
  output logic [7:0]  pd_o,
  output logic        pd_oe_o,
  input  logic [7:0]  pd_i
);
  logic [7:0]  ctrl_q, data_q, reg_rd, seq_byte;
  logic        to_flag, seq_busy, seq_wr, seq_done, seq_fail;
  logic [31:0] seq_res;
  logic        acc, is_epp, gate_ok, start, reg_wr, quick;
  logic [1:0]  last;
  logic [31:0] rd_q;
  logic        ack_q;

  assign acc     = req_i && !seq_busy;
  assign is_epp  = (addr_i == OFF_EADR) || (addr_i == OFF_EDAT);
  assign gate_ok = (ctrl_q & GATE_MASK) == (we_i ? GATE_WR : GATE_RD);
  assign start   = acc && is_epp && gate_ok;
  assign quick   = acc && !start;
  assign reg_wr  = acc && we_i && !is_epp;
  assign last    = (addr_i == OFF_EDAT) ? size_to_last(size_i) : 2'd0;

  epp_host_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i[7:0]),
    .fail_i      (seq_fail),
    .pstat_i     (pstat_i),
    .pd_i        (pd_i),
    .ctrl_o      (ctrl_q),
    .data_o      (data_q),
    .to_o        (to_flag),
    .ctl_load_o  (ctl_load_o),
    .data_load_o (data_load_o),
    .rd_o        (reg_rd)
  );

  epp_host_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wr_i      (we_i),
    .adr_i     (addr_i == OFF_EADR),
    .last_i    (last),
    .wdata_i   (wdata_i),
    .n_wait_i  (n_wait_i),
    .pd_i      (pd_i),
    .busy_o    (seq_busy),
    .wr_o      (seq_wr),
    .done_o    (seq_done),
    .fail_o    (seq_fail),
    .result_o  (seq_res),
    .byte_o    (seq_byte),
    .n_astrb_o (n_astrb_o),
    .n_dstrb_o (n_dstrb_o),
    .n_write_o (n_write_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ack_q <= quick || seq_done;
      if (quick) begin
        if (we_i)        rd_q <= '0;
        else if (is_epp) rd_q <= last_mask(last);
        else             rd_q <= {24'h0, reg_rd};
      end else if (seq_done) begin
        rd_q <= seq_wr ? 32'h0 : seq_res;
      end
    end
  end

  assign rdata_o = rd_q;
  assign ack_o   = ack_q;
  assign busy_o  = seq_busy;
  assign ctl_o   = ctrl_q[3:0];
  assign pd_o    = (seq_busy && seq_wr) ? seq_byte : data_q;
  assign pd_oe_o = seq_busy ? seq_wr : !ctrl_q[CB_DIR];
endmodule

// File: rtl/epp_host_chk.sv
module epp_host_chk #(
  parameter int unsigned TIMEOUT_CYC = 500
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [2:0] addr_i,
  input logic       wbit0,
  input logic       busy_o,
  input logic       ack_o,
  input logic       n_astrb_o,
  input logic       n_dstrb_o,
  input logic       n_write_o,
  input logic       n_wait_i,
  input logic       pd_oe_o,
  input logic       to_q,
  input logic [7:0] ctrl_q
);
  logic        strb_low;
  logic [31:0] low_run;

  assign strb_low = !n_astrb_o || !n_dstrb_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_run <= '0;
    else         low_run <= strb_low ? low_run + 1 : '0;
  end

  p_strb_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!n_astrb_o && !n_dstrb_o));
  p_strb_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_low |-> busy_o);
  p_ack_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_low && n_wait_i) |=> (n_astrb_o && n_dstrb_o));
  p_read_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_low && n_write_o) |-> !pd_oe_o);
  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (((ctrl_q & 8'h2F) == 8'h04) || ((ctrl_q & 8'h2F) == 8'h24)));
  p_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= TIMEOUT_CYC);
  p_to_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_q && !(req_i && !busy_o && we_i && addr_i == 3'd1 && wbit0)) |=> to_q);
endmodule

bind epp_host epp_host_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wbit0     (wdata_i[0]),
  .busy_o    (busy_o),
  .ack_o     (ack_o),
  .n_astrb_o (n_astrb_o),
  .n_dstrb_o (n_dstrb_o),
  .n_write_o (n_write_o),
  .n_wait_i  (n_wait_i),
  .pd_oe_o   (pd_oe_o),
  .to_q      (to_flag),
  .ctrl_q    (ctrl_q)
);

// File: tb/epp_host_test.sv
module epp_host_test;
  localparam int TO = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        busy_o, ack_o, ctl_load_o, data_load_o;
  logic [6:0]  pstat_i = 7'h6C;
  logic [3:0]  ctl_o;
  logic        n_write_o, n_astrb_o, n_dstrb_o;
  logic        n_wait_i = 1'b0;
  logic [7:0]  pd_o, pd_i;
  logic        pd_oe_o;

  epp_host #(.TIMEOUT_CYC(TO)) uut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, fails = 0, cyc = 0;
  int astrb_n = 0, dstrb_n = 0, dl_n = 0, cl_n = 0;
  int low_cnt = 0, max_low = 0, resp_left = -1, resp_dly = 2, mism = 0;
  bit responded = 0, saw_wr_low = 0, saw_wr_high = 0, in_acc = 0, busy_seen = 0;
  logic [7:0] exp_ctrl = 8'hCC, idle_pd = 8'h9C;
  logic [7:0] cap_q[$];
  logic [7:0] rd_q[$];
  logic [31:0] r;

  assign pd_i = (rd_q.size() > 0) ? rd_q[0] : idle_pd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral model and per-clock comparison
  always @(negedge clk_i) begin
    cyc++;
    if (data_load_o) dl_n++;
    if (ctl_load_o) cl_n++;
    if (!n_astrb_o || !n_dstrb_o) begin
      if (low_cnt == 0) begin
        if (!n_astrb_o) astrb_n++; else dstrb_n++;
      end
      low_cnt++;
      if (low_cnt > max_low) max_low = low_cnt;
      if (n_write_o) saw_wr_high = 1; else saw_wr_low = 1;
      if (!n_wait_i && resp_left != 0 && low_cnt >= resp_dly) begin
        if (!n_write_o) cap_q.push_back(pd_o);
        n_wait_i = 1'b1;
        responded = 1;
        if (resp_left > 0) resp_left--;
      end
    end else begin
      if (responded && n_write_o && rd_q.size() > 0) void'(rd_q.pop_front());
      responded = 0;
      low_cnt = 0;
      n_wait_i = 1'b0;
    end
    if (rst_ni && !in_acc && !busy_o) begin
      if (ctl_o !== exp_ctrl[3:0] || pd_oe_o !== !exp_ctrl[5] ||
          !n_astrb_o || !n_dstrb_o || !n_write_o) mism++;
    end
  end

  task automatic acc(input bit we, input [2:0] a, input [1:0] sz,
                     input [31:0] wd, output [31:0] rd);
    int n;
    @(negedge clk_i);
    in_acc = 1; busy_seen = 0;
    req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    n = 0;
    while (!ack_o && n < 2000) begin
      if (busy_o) busy_seen = 1;
      @(negedge clk_i);
      n++;
    end
    if (n >= 2000) chk("R13 ack timeout", 0, 1);
    rd = rdata_o;
    if (we && a == 3'd2) exp_ctrl = wd[7:0] | 8'hC0;
    in_acc = 0;
  endtask

  initial begin
    #50000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int a0, d0, c0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 strobes", {n_astrb_o, n_dstrb_o, n_write_o}, 3'b111);
    rst_ni = 1;
    acc(0, 2, 0, 0, r); chk("R1 ctrl", r, 32'hCC);
    acc(0, 0, 0, 0, r); chk("R1 data", r, 32'hFF);
    acc(0, 1, 0, 0, r); chk("R1 status", r, {24'h0, pstat_i, 1'b0});

    // R5 gated off with reset control (select set)
    a0 = astrb_n; d0 = dstrb_n;
    acc(1, 3, 0, 32'h12, r);
    acc(1, 4, 2, 32'h12345678, r);
    chk("R5 no strobe", astrb_n + dstrb_n, a0 + d0);

    // R2 control write, forced bits, load pulse
    c0 = cl_n;
    acc(1, 2, 0, 32'h04, r);
    acc(0, 2, 0, 0, r); chk("R2 ctrl readback", r, 32'hC4);
    chk("R2 load once", cl_n, c0 + 1);
    acc(1, 2, 0, 32'hC4, r);
    chk("R2 same no load", cl_n, c0 + 1);

    // R3 data latch
    d0 = dl_n;
    acc(1, 0, 0, 32'h5A, r);
    chk("R3 pd_o", pd_o, 8'h5A);
    acc(1, 0, 0, 32'h5A, r);
    chk("R3 load only on change", dl_n, d0 + 1);

    // R7 R8 address write cycle
    cap_q.delete(); a0 = astrb_n; d0 = dstrb_n; saw_wr_low = 0;
    acc(1, 3, 2, 32'hAABB_CC33, r);
    chk("R7 astrb count", astrb_n, a0 + 1);
    chk("R7 dstrb unchanged", dstrb_n, d0);
    chk("R7 nwrite low", saw_wr_low, 1);
    chk("R8 byte", (cap_q.size() == 1) ? cap_q[0] : 8'h00, 8'h33);

    // R11 4-byte write little-endian, R13 busy
    cap_q.delete(); d0 = dstrb_n;
    acc(1, 4, 2, 32'h4433_2211, r);
    chk("R13 busy seen", busy_seen, 1);
    chk("R11 strobes", dstrb_n, d0 + 4);
    chk("R11 order", cap_q.size() == 4 ? {cap_q[3], cap_q[2], cap_q[1], cap_q[0]} : 32'h0,
        32'h4433_2211);

    // R6 reads gated off under write pattern
    d0 = dstrb_n;
    acc(0, 4, 1, 0, r); chk("R6 ones 2B", r, 32'hFFFF);
    acc(0, 4, 3, 0, r); chk("R6 ones 4B", r, 32'hFFFF_FFFF);
    acc(0, 3, 2, 0, r); chk("R6 ones addr", r, 32'hFF);
    chk("R6 no strobe", dstrb_n, d0);

    // R4 direction switch
    acc(1, 2, 0, 32'h24, r);
    chk("R4 oe off", pd_oe_o, 0);
    acc(0, 0, 0, 0, r); chk("R4 data in", r, {24'h0, idle_pd});

    // R6 R11 read cycle, 2 bytes
    rd_q = '{8'hA1, 8'hB2}; saw_wr_high = 0; resp_dly = 3;
    acc(0, 4, 1, 0, r);
    chk("R11 read LE", r, 32'h0000_B2A1);
    chk("R7 nwrite high", saw_wr_high, 1);

    // R9 timeout on address read
    resp_left = 0; max_low = 0;
    acc(0, 3, 0, 0, r);
    chk("R9 rdata", r, 32'hFF);
    chk("R9 strobe window", max_low, TO);
    acc(0, 1, 0, 0, r); chk("R9 sticky", r[0], 1);

    // R10 clear
    acc(1, 1, 0, 32'h00, r);
    acc(0, 1, 0, 0, r); chk("R10 bit0=0 keeps", r[0], 1);
    acc(1, 1, 0, 32'h01, r);
    acc(0, 1, 0, 0, r); chk("R10 clear", r, {24'h0, pstat_i, 1'b0});

    // R12 partial read
    rd_q = '{8'h11, 8'h22}; resp_left = 2; d0 = dstrb_n;
    acc(0, 4, 2, 0, r);
    chk("R12 partial", r, 32'hFFFF_2211);
    chk("R12 stops", dstrb_n, d0 + 3);
    acc(0, 1, 0, 0, r); chk("R12 flag", r[0], 1);

    chk("R2 R4 per-clock shadow", mism, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule